// File: doc/BRIEF.md
# Debug Execute Command Decoder

This block sits between a serial debug port and a processor's run-control state machine. Each time the port finishes an Execute message, it raises a one-cycle strobe. At that moment it presents the message's command byte, the 16-bit instruction word carried with it, and the current system state. The decoder turns the command into single-cycle request pulses for stepping, starting, stopping and resetting the core, and into write strobes for instruction memory and for the compare-mask register. It also keeps two held controls: one selects where the core's decoder takes its instruction from, and one arms the instruction-compare trap.

The command field occupies bits 4 to 1 of the byte. Bit 0 chooses an injected instruction over the fetched one, and only counts for the no-operation and step commands. Bit 7 turns a plain start into a start with the compare trap armed. Bits 6 and 5 are reserved. Most commands are legal only while the core is stopped. A command that arrives in the wrong state is discarded, and a sticky error flag is raised that only the block reset clears. All outputs are registered, so they appear one clock after the strobe.

Top module: `dbg_exec_decoder`

## Requirements
- R1: After rst_n is asserted low, every request pulse, pc_adv, src_inject, trap_en and cmd_err are 0.
- R2: Outputs change only in response to exec_stb. The clock after a strobe, exactly one action pulse is raised for a legal command: field bits[4:1] 0001 gives step_req, 0010 start_req, 0011 stop_req, 0100 reset_req, 0101 imem_we and 0110 mask_we. Each pulse lasts one cycle, and no pulse appears without a strobe.
- R3: STEP (0x02) pulses step_req together with pc_adv. STEPX (0x03) pulses step_req with pc_adv held low.
- R4: An accepted command with field 0000 or 0001 loads src_inject from bit 0, so 0x00 and 0x02 give 0, and 0x01 and 0x03 give 1. Every other legal command leaves src_inject unchanged.
- R5: An accepted START (field 0010) loads trap_en from bit 7, so 0x84 gives 1 and 0x04 gives 0. RESET (field 0100) clears trap_en. Every other command leaves trap_en unchanged.
- R6: NOPX, STEP, STEPX, START, the memory write and the mask write are accepted only when sys_state equals 2'b10, the stopped state. The other encodings are 2'b00 halted, 2'b01 loading and 2'b11 running. NOP, STOP and RESET are accepted in every state.
- R7: A rejected command raises no pulse, leaves src_inject, trap_en and op_word unchanged, and sets cmd_err. Once set, cmd_err stays at 1 until rst_n is asserted.
- R8: An accepted memory or mask write presents on op_word the instr_buf value that was present at the strobe, in the same cycle as its write pulse.
- R9: Bits 6 and 5 never change the outcome. Bit 7 matters only for START.
- R10: Field codes 0111 through 1111 act as command 0x00. They raise no pulse, clear src_inject and never set cmd_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_stb | input | 1 | One-cycle strobe marking a complete Execute message |
| cmd_byte | input | 8 | Command byte of the message |
| instr_buf | input | 16 | Instruction word carried by the message |
| sys_state | input | 2 | Run-control state (00 halted, 01 loading, 10 stopped, 11 running) |
| step_req | output | 1 | Pulse: execute one instruction |
| pc_adv | output | 1 | Pulse: the step advances PC |
| start_req | output | 1 | Pulse: resume execution |
| stop_req | output | 1 | Pulse: interrupt execution |
| reset_req | output | 1 | Pulse: halt everything |
| imem_we | output | 1 | Pulse: write op_word to instruction memory at PC |
| mask_we | output | 1 | Pulse: write op_word to the compare mask |
| op_word | output | 16 | Instruction word captured by the last command that uses it |
| src_inject | output | 1 | Held: decoder takes the injected instruction |
| trap_en | output | 1 | Held: instruction-compare trap armed |
| cmd_err | output | 1 | Sticky: a command arrived in a state that forbids it |

## Verification
The bench sends every command byte in every system state. It starts once with both held controls cleared and once with both set, so any command that disturbs a control it should leave alone shows up as a wrong held value. A decoder that gated on the wrong state would pulse steps while running, or reject STOP. A decoder that decoded bit 0 for START or the writes, or bit 7 for anything but START, would flip src_inject or trap_en on those bytes. A decoder that treated the undefined field codes as errors, or cleared the error flag on a later good command, would show the wrong cmd_err value.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;

  typedef enum logic [3:0] {
    OP_NOP, OP_NOPX, OP_STEP, OP_STEPX, OP_START,
    OP_STOP, OP_RESET, OP_WRIMEM, OP_WRMASK
  } op_e;

  localparam int CMD_W      = 8;
  localparam int FIELD_LSB  = 1;
  localparam int FIELD_W    = 4;
  localparam int SRC_BIT    = 0;
  localparam int TRAP_BIT   = 7;

  // Order of action pulses inside the pulse vector
  localparam int P_STEP  = 0;
  localparam int P_START = 1;
  localparam int P_STOP  = 2;
  localparam int P_RESET = 3;
  localparam int P_IMEM  = 4;
  localparam int P_MASK  = 5;
  localparam int NPULSE  = 6;

  function automatic op_e decode_op(input logic [CMD_W-1:0] cmd);
    logic [FIELD_W-1:0] field;
    op_e op;
    field = cmd[FIELD_LSB +: FIELD_W];
    case (field)
      4'd0:    op = cmd[SRC_BIT] ? OP_NOPX  : OP_NOP;
      4'd1:    op = cmd[SRC_BIT] ? OP_STEPX : OP_STEP;
      4'd2:    op = OP_START;
      4'd3:    op = OP_STOP;
      4'd4:    op = OP_RESET;
      4'd5:    op = OP_WRIMEM;
      4'd6:    op = OP_WRMASK;
      default: op = OP_NOP;
    endcase
    return op;
  endfunction

  function automatic logic needs_stop(input op_e op);
    return (op == OP_NOPX)   || (op == OP_STEP)   || (op == OP_STEPX) ||
           (op == OP_START)  || (op == OP_WRIMEM) || (op == OP_WRMASK);
  endfunction

  function automatic logic [NPULSE-1:0] pulses_of(input op_e op);
    logic [NPULSE-1:0] p;
    p = '0;
    p[P_STEP]  = (op == OP_STEP) || (op == OP_STEPX);
    p[P_START] = (op == OP_START);
    p[P_STOP]  = (op == OP_STOP);
    p[P_RESET] = (op == OP_RESET);
    p[P_IMEM]  = (op == OP_WRIMEM);
    p[P_MASK]  = (op == OP_WRMASK);
    return p;
  endfunction

  function automatic logic sets_source(input op_e op);
    return (op == OP_NOP) || (op == OP_NOPX) || (op == OP_STEP) || (op == OP_STEPX);
  endfunction

  function automatic logic uses_word(input op_e op);
    return (op == OP_NOPX) || (op == OP_STEPX) || (op == OP_WRIMEM) || (op == OP_WRMASK);
  endfunction

endpackage

// File: rtl/dbg_cmd_classify.sv
module dbg_cmd_classify
  import dbg_exec_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output op_e              op,
  output logic             trap_bit
);
  logic unused_rsv;

  assign op         = decode_op(cmd);
  assign trap_bit   = cmd[TRAP_BIT];
  assign unused_rsv = ^cmd[6:5];
endmodule

// File: rtl/dbg_state_gate.sv
module dbg_state_gate
  import dbg_exec_pkg::*;
#(
  parameter int              ST_W       = 2,
  parameter logic [ST_W-1:0] STOP_STATE = 2'b10
) (
  input  logic            exec_stb,
  input  op_e             op,
  input  logic [ST_W-1:0] sys_state,
  output logic            accept,
  output logic            reject
);
  logic state_fits;

  assign state_fits = !needs_stop(op) || (sys_state == STOP_STATE);
  assign accept     = exec_stb &&  state_fits;
  assign reject     = exec_stb && !state_fits;
endmodule

// File: rtl/dbg_action_regs.sv
module dbg_action_regs
  import dbg_exec_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               reject,
  input  op_e                op,
  input  logic               trap_bit,
  input  logic [INSTR_W-1:0] instr_buf,
  output logic [NPULSE-1:0]  pulse_q,
  output logic               pc_adv,
  output logic [INSTR_W-1:0] op_word,
  output logic               src_inject,
  output logic               trap_en,
  output logic               cmd_err
);
  logic [NPULSE-1:0] pulse_d;

  assign pulse_d = accept ? pulses_of(op) : '0;

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[i] <= 1'b0;
      else        pulse_q[i] <= pulse_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_adv     <= 1'b0;
      op_word    <= '0;
      src_inject <= 1'b0;
      trap_en    <= 1'b0;
      cmd_err    <= 1'b0;
    end else begin
      pc_adv <= accept && (op == OP_STEP);
      if (accept && uses_word(op))   op_word    <= instr_buf;
      if (accept && sets_source(op)) src_inject <= (op == OP_NOPX) || (op == OP_STEPX);
      if (accept && op == OP_START)  trap_en    <= trap_bit;
      else if (accept && op == OP_RESET) trap_en <= 1'b0;
      if (reject) cmd_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_exec_decoder.sv
module dbg_exec_decoder
  import dbg_exec_pkg::*;
#(
  parameter int              INSTR_W    = 16,
  parameter int              ST_W       = 2,
  parameter logic [ST_W-1:0] STOP_STATE = 2'b10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_stb,
  input  logic [7:0]         cmd_byte,
  input  logic [INSTR_W-1:0] instr_buf,
  input  logic [ST_W-1:0]    sys_state,
  output logic               step_req,
  output logic               pc_adv,
  output logic               start_req,
  output logic               stop_req,
  output logic               reset_req,
  output logic               imem_we,
  output logic               mask_we,
  output logic [INSTR_W-1:0] op_word,
  output logic               src_inject,
  output logic               trap_en,
  output logic               cmd_err
);
  op_e               op_cur;
  logic              trap_bit;
  logic              cmd_accept;
  logic              cmd_reject;
  logic [NPULSE-1:0] pulse_vec;

  dbg_cmd_classify u_classify (
    .cmd      (cmd_byte),
    .op       (op_cur),
    .trap_bit (trap_bit)
  );

  dbg_state_gate #(.ST_W(ST_W), .STOP_STATE(STOP_STATE)) u_gate (
    .exec_stb  (exec_stb),
    .op        (op_cur),
    .sys_state (sys_state),
    .accept    (cmd_accept),
    .reject    (cmd_reject)
  );

  dbg_action_regs #(.INSTR_W(INSTR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (cmd_accept),
    .reject     (cmd_reject),
    .op         (op_cur),
    .trap_bit   (trap_bit),
    .instr_buf  (instr_buf),
    .pulse_q    (pulse_vec),
    .pc_adv     (pc_adv),
    .op_word    (op_word),
    .src_inject (src_inject),
    .trap_en    (trap_en),
    .cmd_err    (cmd_err)
  );

  assign step_req  = pulse_vec[P_STEP];
  assign start_req = pulse_vec[P_START];
  assign stop_req  = pulse_vec[P_STOP];
  assign reset_req = pulse_vec[P_RESET];
  assign imem_we   = pulse_vec[P_IMEM];
  assign mask_we   = pulse_vec[P_MASK];
endmodule

// File: rtl/dbg_exec_checker.sv
module dbg_exec_checker #(
  parameter int              ST_W       = 2,
  parameter logic [ST_W-1:0] STOP_STATE = 2'b10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exec_stb,
  input logic [ST_W-1:0] sys_state,
  input logic            cmd_accept,
  input logic            cmd_reject,
  input logic            step_req,
  input logic            pc_adv,
  input logic            start_req,
  input logic            stop_req,
  input logic            reset_req,
  input logic            imem_we,
  input logic            mask_we,
  input logic            trap_en,
  input logic            cmd_err
);
  logic any_pulse;
  assign any_pulse = step_req | start_req | stop_req | reset_req | imem_we | mask_we;

  a_r2_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(exec_stb));

  a_r2_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_req, start_req, stop_req, reset_req, imem_we, mask_we}));

  a_r3_pc_adv_with_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |-> step_req);

  a_r6_stopped_only: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req | start_req | imem_we | mask_we) |-> ($past(sys_state) == STOP_STATE));

  a_r7_reject_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> !any_pulse);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $past(cmd_reject));

  a_r5_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_accept) |-> $stable(trap_en));
endmodule

bind dbg_exec_decoder dbg_exec_checker #(.ST_W(ST_W), .STOP_STATE(STOP_STATE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_stb   (exec_stb),
  .sys_state  (sys_state),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject),
  .step_req   (step_req),
  .pc_adv     (pc_adv),
  .start_req  (start_req),
  .stop_req   (stop_req),
  .reset_req  (reset_req),
  .imem_we    (imem_we),
  .mask_we    (mask_we),
  .trap_en    (trap_en),
  .cmd_err    (cmd_err)
);

// File: tb/sim_dbg_exec_decoder.sv
`timescale 1ns/1ps
module sim_dbg_exec_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_stb = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic [15:0] instr_buf = 16'h0000;
  logic [1:0]  sys_state = 2'b00;
  logic        step_req, pc_adv, start_req, stop_req, reset_req, imem_we, mask_we;
  logic [15:0] op_word;
  logic        src_inject, trap_en, cmd_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dbg_exec_decoder u0 (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .cmd_byte(cmd_byte),
    .instr_buf(instr_buf), .sys_state(sys_state),
    .step_req(step_req), .pc_adv(pc_adv), .start_req(start_req),
    .stop_req(stop_req), .reset_req(reset_req), .imem_we(imem_we),
    .mask_we(mask_we), .op_word(op_word), .src_inject(src_inject),
    .trap_en(trap_en), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cmd %h state %0d)",
               tag, act, exp, cmd_byte, sys_state);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; exec_stb = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] c, input logic [1:0] st, input logic [15:0] w);
    @(negedge clk);
    cmd_byte = c; sys_state = st; instr_buf = w; exec_stb = 1'b1;
    @(negedge clk);
    exec_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 pulses", {10'b0, step_req, start_req, stop_req, reset_req, imem_we, mask_we}, 16'h0);
    chk("R1 pc_adv", {15'b0, pc_adv}, 16'h0);
    chk("R1 src_inject", {15'b0, src_inject}, 16'h0);
    chk("R1 trap_en", {15'b0, trap_en}, 16'h0);
    chk("R1 cmd_err", {15'b0, cmd_err}, 16'h0);

    // R2: a command on the bus without a strobe does nothing
    @(negedge clk); cmd_byte = 8'h02; sys_state = 2'b10; exec_stb = 1'b0;
    @(negedge clk);
    chk("R2 no strobe no step", {15'b0, step_req}, 16'h0);
    @(negedge clk); cmd_byte = 8'h84;
    @(negedge clk);
    chk("R2 no strobe no start", {15'b0, start_req}, 16'h0);
    chk("R2 no strobe trap held", {15'b0, trap_en}, 16'h0);

    // Sweep: R2..R10, every byte in every state, from two held starting points
    for (int p = 0; p < 2; p++) begin
      for (int st = 0; st < 4; st++) begin
        for (int c = 0; c < 256; c++) begin
          logic [3:0] f;
          logic [15:0] w;
          logic ok, needs, e_src, e_trap;
          do_reset();
          if (p == 1) begin
            send(8'h84, 2'b10, 16'h0);
            send(8'h01, 2'b10, 16'h0);
          end
          w = {c[7:0], ~c[7:0]} ^ {st[1:0], 14'h1234};
          f = c[4:1];
          needs = ((f == 4'd0) && c[0]) || (f == 4'd1) || (f == 4'd2) ||
                  (f == 4'd5) || (f == 4'd6);
          ok = !needs || (st == 2);
          e_src  = (p == 1);
          e_trap = (p == 1);
          if (ok && (f == 4'd0 || f == 4'd1)) e_src = c[0];   // R4
          if (f > 4'd6) e_src = 1'b0;                          // R10
          if (ok && f == 4'd2) e_trap = c[7];                  // R5
          if (f == 4'd4) e_trap = 1'b0;                        // R5
          send(c[7:0], st[1:0], w);
          // R2, R6, R9, R10 pulses
          chk("R2 step_req",  {15'b0, step_req},  {15'b0, ok && f == 4'd1});
          chk("R2 start_req", {15'b0, start_req}, {15'b0, ok && f == 4'd2});
          chk("R2 stop_req",  {15'b0, stop_req},  {15'b0, f == 4'd3});
          chk("R2 reset_req", {15'b0, reset_req}, {15'b0, f == 4'd4});
          chk("R6 imem_we",   {15'b0, imem_we},   {15'b0, ok && f == 4'd5});
          chk("R6 mask_we",   {15'b0, mask_we},   {15'b0, ok && f == 4'd6});
          chk("R3 pc_adv",    {15'b0, pc_adv},    {15'b0, ok && f == 4'd1 && !c[0]});
          chk("R4 src_inject", {15'b0, src_inject}, {15'b0, e_src});
          chk("R5 trap_en",   {15'b0, trap_en},   {15'b0, e_trap});
          chk("R7 cmd_err",   {15'b0, cmd_err},   {15'b0, !ok});
          if (ok && (f == 4'd5 || f == 4'd6))
            chk("R8 op_word", op_word, w);
          if (!ok && p == 1)
            chk("R7 op_word kept", op_word, 16'h0);
          // R2: pulses last one cycle
          @(negedge clk);
          chk("R2 pulse width", {10'b0, step_req, start_req, stop_req, reset_req, imem_we, mask_we}, 16'h0);
        end
      end
    end

    // R7: error survives a later legal command, clears only on reset
    do_reset();
    send(8'h02, 2'b11, 16'h0);
    send(8'h00, 2'b10, 16'h0);
    chk("R7 err sticky", {15'b0, cmd_err}, 16'h1);
    send(8'h08, 2'b11, 16'h0);
    chk("R7 err sticky after reset cmd", {15'b0, cmd_err}, 16'h1);
    do_reset();
    chk("R1 err cleared by rst_n", {15'b0, cmd_err}, 16'h0);

    // R5: trap stays armed across STEP and STOP, cleared by RESET
    send(8'h84, 2'b10, 16'h0);
    send(8'h02, 2'b10, 16'h0);
    send(8'h06, 2'b11, 16'h0);
    chk("R5 trap held", {15'b0, trap_en}, 16'h1);
    send(8'h08, 2'b11, 16'h0);
    chk("R5 trap cleared by reset", {15'b0, trap_en}, 16'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule